// File: doc/BRIEF.md
# Cascade Summer and Output Formatter

This block is the last stage of one channel in a chain of cascaded modulators. On every clock it adds the channel's own 16-bit modulated sample to a 16-bit two's complement sample arriving from the channel upstream. It clamps the result to the 16-bit range and registers it. The registered value is then presented either as two's complement or as offset binary, depending on a static select pin.

A static zero control replaces the upstream sample with zero. The first channel of a chain, or a channel used alone, sets this control. An active-low output-enable is converted into a drive flag. The pad ring uses that flag to switch the output bus between driven and high-impedance. The data path itself is never tri-stated inside the block.

Top module: `duc_cas_out`

## Requirements
- R1: The output value seen after a rising clock edge equals the sum of `local_i` and the upstream sample, both taken at that same edge. There is exactly one register of latency, and the output holds until the next edge.
- R2: While `cas_zero_i` is high at a clock edge, `cas_i` has no effect, and the registered result equals `local_i` alone.
- R3: When the true sum is above +32767, the registered two's complement result is 0x7FFF.
- R4: When the true sum is below -32768, the registered two's complement result is 0x8000.
- R5: With `fmt_twos_i` high, `data_o` carries the saturated result unchanged, as two's complement.
- R6: With `fmt_twos_i` low, `data_o` carries the saturated result with bit 15 inverted, which is offset binary. The format is applied after the register, so a change of the select shows on `data_o` without waiting for a clock edge.
- R7: `drive_o` is the inverse of `oe_ni`. The value on `data_o` does not depend on `oe_ni`.
- R8: While `rst_ni` is low, the register is cleared asynchronously. `data_o` then shows the code for zero in the selected format: 0x0000 in two's complement, 0x8000 in offset binary.
- R9: Sums that land exactly on +32767 or -32768 pass through unclamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all registers use the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| local_i | input | 16 | Local modulated sample, two's complement |
| cas_i | input | 16 | Upstream cascade sample, two's complement |
| cas_zero_i | input | 1 | High: use zero in place of `cas_i` |
| fmt_twos_i | input | 1 | High: two's complement output; low: offset binary |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 16 | Registered, saturated and formatted sample |
| drive_o | output | 1 | High when the output pads should drive the bus |

## Verification
The block holds only one register, so any error in the adder, the clamp or the zero gate shows on `data_o` exactly one clock after the faulty inputs. It never shows later and never accumulates. The two clamp boundaries and the two exact-limit sums separate a wrapping adder from a saturating one. They also catch a clamp that fires one code too early. A bit 15 that is wrong in only one format points to the formatter rather than to the register. That kind of fault can be seen with no clock at all, by toggling the format select or by holding reset.

// File: rtl/duc_cas_pkg.sv
package duc_cas_pkg;
  localparam int unsigned SAMPLE_W = 16;
endpackage

// File: rtl/duc_cas_gate.sv
module duc_cas_gate #(
  parameter int unsigned W = duc_cas_pkg::SAMPLE_W
) (
  input  logic [W-1:0] cas_i,
  input  logic         zero_i,
  output logic [W-1:0] cas_o
);
  assign cas_o = zero_i ? '0 : cas_i;
endmodule

// File: rtl/duc_sat_add.sv
module duc_sat_add #(
  parameter int unsigned W = duc_cas_pkg::SAMPLE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W:0] wide;

  // one guard bit; overflow when guard and sign disagree
  assign wide = {a_i[W-1], a_i} + {b_i[W-1], b_i};

  always_comb begin
    if (wide[W] != wide[W-1]) sum_o = wide[W] ? MAX_NEG : MAX_POS;
    else                      sum_o = wide[W-1:0];
  end
endmodule

// File: rtl/duc_out_fmt.sv
module duc_out_fmt #(
  parameter int unsigned W = duc_cas_pkg::SAMPLE_W
) (
  input  logic [W-1:0] tc_i,
  input  logic         twos_i,
  output logic [W-1:0] out_o
);
  assign out_o = {tc_i[W-1] ^ ~twos_i, tc_i[W-2:0]};
endmodule

// File: rtl/duc_cas_out.sv
module duc_cas_out #(
  parameter int unsigned W = duc_cas_pkg::SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] local_i,
  input  logic [W-1:0] cas_i,
  input  logic         cas_zero_i,
  input  logic         fmt_twos_i,
  input  logic         oe_ni,
  output logic [W-1:0] data_o,
  output logic         drive_o
);
  logic [W-1:0] cas_g;
  logic [W-1:0] sat_sum;
  logic [W-1:0] sum_q;

  duc_cas_gate #(.W(W)) u_gate (
    .cas_i  (cas_i),
    .zero_i (cas_zero_i),
    .cas_o  (cas_g)
  );

  duc_sat_add #(.W(W)) u_add (
    .a_i   (local_i),
    .b_i   (cas_g),
    .sum_o (sat_sum)
  );

  // register holds two's complement; format applied after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sat_sum;
  end

  duc_out_fmt #(.W(W)) u_fmt (
    .tc_i   (sum_q),
    .twos_i (fmt_twos_i),
    .out_o  (data_o)
  );

  assign drive_o = ~oe_ni;
endmodule

// File: rtl/duc_cas_out_chk.sv
module duc_cas_out_chk #(
  parameter int unsigned W = duc_cas_pkg::SAMPLE_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] local_i,
  input logic [W-1:0] cas_i,
  input logic         cas_zero_i,
  input logic         fmt_twos_i,
  input logic         oe_ni,
  input logic [W-1:0] data_o,
  input logic         drive_o
);
  localparam logic signed [W:0] LIM_POS = (W+1)'(2**(W-1) - 1);
  localparam logic signed [W:0] LIM_NEG = -(W+1)'(2**(W-1));

  logic signed [W:0] ext_sum;
  logic signed [W:0] sum_q;
  logic [W-1:0]      local_q;
  logic              cz_q;
  logic              seen_q;
  logic [W-1:0]      tc_out;

  assign ext_sum = $signed({local_i[W-1], local_i}) +
                   (cas_zero_i ? '0 : $signed({cas_i[W-1], cas_i}));
  assign tc_out  = {data_o[W-1] ^ ~fmt_twos_i, data_o[W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      local_q <= '0;
      cz_q    <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      sum_q   <= ext_sum;
      local_q <= local_i;
      cz_q    <= cas_zero_i;
      seen_q  <= 1'b1;
    end
  end

  assert_exact_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && sum_q <= LIM_POS && sum_q >= LIM_NEG |-> tc_out == sum_q[W-1:0]);

  assert_cas_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && cz_q |-> tc_out == local_q);

  assert_pos_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && sum_q > LIM_POS |-> tc_out == {1'b0, {(W-1){1'b1}}});

  assert_neg_clamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && sum_q < LIM_NEG |-> tc_out == {1'b1, {(W-1){1'b0}}});

  assert_twos_fmt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && fmt_twos_i && !cz_q && sum_q <= LIM_POS && sum_q >= LIM_NEG
    |-> data_o == sum_q[W-1:0]);

  assert_offset_fmt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !fmt_twos_i && cz_q |-> data_o == {~local_q[W-1], local_q[W-2:0]});

  assert_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o != oe_ni);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_code_R8: assert (data_o == {~fmt_twos_i, {(W-1){1'b0}}});
    end
  end
endmodule

bind duc_cas_out duc_cas_out_chk #(.W(W)) u_chk (.*);

// File: tb/duc_cas_out_bench.sv
module duc_cas_out_bench;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] exp_tc;
    string        req;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] local_i = '0;
  logic [W-1:0] cas_i = '0;
  logic         cas_zero_i = 1'b0;
  logic         fmt_twos_i = 1'b1;
  logic         oe_ni = 1'b0;
  logic [W-1:0] data_o;
  logic         drive_o;

  int n_chk = 0;
  int n_bad = 0;
  item_t sb[$];

  always #4 clk_i = ~clk_i;

  duc_cas_out u_duc_cas_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .local_i(local_i), .cas_i(cas_i),
    .cas_zero_i(cas_zero_i), .fmt_twos_i(fmt_twos_i), .oe_ni(oe_ni),
    .data_o(data_o), .drive_o(drive_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic z);
    int s;
    s = int'($signed(a)) + (z ? 0 : int'($signed(b)));
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return W'(s);
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic z, input string req);
    item_t it;
    @(negedge clk_i);
    local_i    = a;
    cas_i      = b;
    cas_zero_i = z;
    it.exp_tc  = model(a, b, z);
    it.req     = req;
    sb.push_back(it);
  endtask

  // monitor: checks the item captured at the preceding edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.req, data_o, fmt_twos_i ? it.exp_tc : {~it.exp_tc[W-1], it.exp_tc[W-2:0]});
      end
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    #10;
    check("R8", data_o, 16'h0000);
    fmt_twos_i = 1'b0;
    #1;
    check("R8", data_o, 16'h8000);
    fmt_twos_i = 1'b1;
    @(negedge clk_i) rst_ni = 1'b1;

    drive(16'h0123, 16'h0456, 1'b0, "R1");
    drive(16'hFF00, 16'h0010, 1'b0, "R1");
    drive(16'h8000, 16'h7FFF, 1'b0, "R1");
    drive(16'h1000, 16'h7000, 1'b1, "R2");
    drive(16'hF000, 16'h8000, 1'b1, "R2");
    drive(16'h4000, 16'h4000, 1'b0, "R3");
    drive(16'h7FFF, 16'h7FFF, 1'b0, "R3");
    drive(16'hC000, 16'hBFFF, 1'b0, "R4");
    drive(16'h8000, 16'h8000, 1'b0, "R4");
    drive(16'h7FFF, 16'h0000, 1'b0, "R9");
    drive(16'h4000, 16'h3FFF, 1'b0, "R9");
    drive(16'h8000, 16'h0000, 1'b0, "R9");
    drive(16'hC000, 16'hC000, 1'b0, "R9");
    drive(16'h1234, 16'h0000, 1'b0, "R5");
    repeat (2) @(negedge clk_i);
    check("R5", data_o, 16'h1234);
    fmt_twos_i = 1'b0;
    #1;
    check("R6", data_o, 16'h9234);
    drive(16'hFFFF, 16'h0000, 1'b0, "R6");
    drive(16'h2000, 16'h7000, 1'b0, "R6");
    drive(16'hE000, 16'h9000, 1'b0, "R6");
    repeat (2) @(negedge clk_i);
    fmt_twos_i = 1'b1;
    oe_ni = 1'b1;
    #1;
    check("R7", {15'b0, drive_o}, 16'h0000);
    check("R7", data_o, 16'h8000);
    drive(16'h0042, 16'h0001, 1'b0, "R7");
    @(negedge clk_i);
    oe_ni = 1'b0;
    #1;
    check("R7", {15'b0, drive_o}, 16'h0001);
    rst_ni = 1'b0;
    #1;
    check("R8", data_o, 16'h0000);
    @(negedge clk_i);
    check("R8", data_o, 16'h0000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule